// File: doc/BRIEF.md
# Masked Event Status Interrupt Aggregator

The aggregator collects a parameterised number of single-bit hardware event lines (96 by default) into sticky status bits held in 32-bit words. An event pulse latches its bit. The bit stays set until software writes a 1 to that bit position. Three independent mask groups each keep a full set of mask words that line up with the status words. Each group drives one level-sensitive interrupt line. That line is high while any latched status bit is also enabled in the group's matching mask word.

Software reaches the block through a plain 32-bit register port. A write takes effect on the clock edge where the one-cycle strobe is seen. A read returns its data one cycle after the read strobe. Status words sit at byte offsets 0x00, 0x04 and 0x08. Mask group g starts at offset 0x10·(g+1), and its words sit at +0x0, +0x4 and +0x8 for status words 0, 1 and 2. Group 0 feeds the output for line 13, group 1 the output for line 11 and group 2 the output for line 9.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status bit and every mask bit reads 0, and all three interrupt outputs are low.
- R2: A high event input k sets bit k%32 of status word k/32 on the next clock edge, and the bit stays set after the input falls.
- R3: Writing status word w (byte offset 4·w) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an event input and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: A write to mask word w of group g (byte offset 0x10·(g+1)+4·w) stores the full 32-bit value. The same offset reads it back unchanged.
- R6: A status read returns the raw latched bits and is not affected by any mask.
- R7: Interrupt output g is high exactly when some status bit is set and the same bit is set in group g's mask word for that status word. It follows register state with no added delay.
- R8: The groups are independent. A bit enabled only in group g raises only output g.
- R9: An output stays high until every enabled pending bit of its group has been cleared or masked off.
- R10: Read data appears one cycle after the read strobe. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 96 | Hardware event lines, sampled every cycle |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| irq_o | output | 3 | Interrupt lines, index = mask group |

## Verification
The bench sends an event and a clear to the same bit in the same cycle. A design where the clear wins would drop the event and show a 0 on the next status read. It enables a bit in only one group and watches all three outputs. A design with a crossed mask-word index or crossed group wiring would raise the wrong line, or raise it for an event from the wrong word. It clears two pending bits one at a time. An OR-reduction that covers only part of the word would drop the line too early. It also reads unmapped offsets such as 0x0C and 0x1C, where an incomplete decoder would alias a real register.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [1:0] grp;
    logic [1:0] word;
  } reg_dec_t;

  // Byte offset decode: status at 4*w, mask group g at 0x10*(g+1)+4*w.
  function automatic reg_dec_t decode_offset(input logic [ADDR_W-1:0] a,
                                             input int unsigned nw,
                                             input int unsigned ng);
    reg_dec_t d;
    logic [3:0] hi;
    logic [1:0] lo;
    hi = a[7:4];
    lo = a[3:2];
    d.sel  = SEL_NONE;
    d.grp  = 2'd0;
    d.word = lo;
    if (a[1:0] == 2'b00 && 32'(lo) < nw) begin
      if (hi == 4'd0) begin
        d.sel = SEL_STAT;
      end else if (32'(hi) <= ng) begin
        d.sel = SEL_MASK;
        d.grp = 2'(hi - 4'd1);
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/evt_status_word.sv
module evt_status_word
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] clr_bits,
  output logic [WORD_W-1:0] stat
);
  logic [WORD_W-1:0] clr_eff;
  logic [WORD_W-1:0] stat_nxt;

  assign clr_eff  = clr_en ? clr_bits : '0;
  assign stat_nxt = (stat & ~clr_eff) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_nxt;
  end

  // R2
  evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
  // R4
  evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ((evt & clr_bits) != '0)) |=> ((stat & $past(evt & clr_bits)) == $past(evt & clr_bits)));
  // R3
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((stat & ~$past(clr_bits)) == ($past(stat | evt) & ~$past(clr_bits))));
endmodule

// File: rtl/evt_mask_group.sv
module evt_mask_group
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_WORDS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_word,
  input  logic [WORD_W-1:0]         wdata,
  input  logic [N_WORDS*WORD_W-1:0] stat_all,
  output logic [N_WORDS*WORD_W-1:0] mask_all,
  output logic                      irq
);
  logic [N_WORDS-1:0] word_hit;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) mask_all[w*WORD_W +: WORD_W] <= '0;
      else if (wr_en && wr_word == 2'(w)) mask_all[w*WORD_W +: WORD_W] <= wdata;
    end
    assign word_hit[w] = |(stat_all[w*WORD_W +: WORD_W] & mask_all[w*WORD_W +: WORD_W]);
  end

  assign irq = |word_hit;

  // R5
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_all[WORD_W*$past(wr_word) +: WORD_W] == $past(wdata)));
  // R7
  irq_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == '0) |-> !irq);
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_EVT    = 96,
  parameter int unsigned N_GROUPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_EVT-1:0]      evt_i,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  output logic [N_GROUPS-1:0]   irq_o
);
  localparam int unsigned N_WORDS = N_EVT / WORD_W;
  localparam int unsigned TOT_W   = N_WORDS * WORD_W;

  reg_dec_t             dec;
  logic [TOT_W-1:0]     stat_all;
  logic [TOT_W-1:0]     mask_all [N_GROUPS];
  logic [N_WORDS-1:0]   stat_clr_en;
  logic [N_GROUPS-1:0]  mask_wr_en;
  logic [WORD_W-1:0]    rd_mux;

  assign dec = decode_offset(addr, N_WORDS, N_GROUPS);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_stat
    assign stat_clr_en[w] = wr_en && dec.sel == SEL_STAT && dec.word == 2'(w);
    evt_status_word u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i[w*WORD_W +: WORD_W]),
      .clr_en   (stat_clr_en[w]),
      .clr_bits (wdata),
      .stat     (stat_all[w*WORD_W +: WORD_W])
    );
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign mask_wr_en[g] = wr_en && dec.sel == SEL_MASK && dec.grp == 2'(g);
    evt_mask_group #(.N_WORDS(N_WORDS)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mask_wr_en[g]),
      .wr_word  (dec.word),
      .wdata    (wdata),
      .stat_all (stat_all),
      .mask_all (mask_all[g]),
      .irq      (irq_o[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (dec.sel)
      SEL_STAT: rd_mux = stat_all[WORD_W*dec.word +: WORD_W];
      SEL_MASK: rd_mux = mask_all[dec.grp][WORD_W*dec.word +: WORD_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |-> (irq_o == '0));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dec.sel == SEL_NONE) |=> (rdata == '0));
  // R9
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_all == '0) |-> (irq_o == '0));
endmodule

// File: tb/test_evt_irq_agg.sv
module test_evt_irq_agg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [95:0] evt_i = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_agg i_evt_irq_agg (.*);

  // vector: op(0=write,1=read-check,2=irq-check,3=pulse event), addr/evt index, data, expect
  typedef struct packed { logic [1:0] op; logic [7:0] a; logic [31:0] d; } vec_t;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 8'd5,    32'h0},         // event 5
    '{2'd1, 8'h00,   32'h0000_0020}, // R2 status0
    '{2'd2, 8'h00,   32'h0},         // R7 no mask -> no irq
    '{2'd0, 8'h10,   32'h0000_0020}, // group0 word0
    '{2'd2, 8'h00,   32'h1},         // R8 only irq0
    '{2'd3, 8'd40,   32'h0},         // event 40 -> word1 bit8
    '{2'd1, 8'h04,   32'h0000_0100}, // R6 raw
    '{2'd0, 8'h24,   32'h0000_0100}, // group1 word1
    '{2'd2, 8'h00,   32'h3},
    '{2'd0, 8'h00,   32'h0000_0020}, // clear bit5
    '{2'd2, 8'h00,   32'h2},         // R9
    '{2'd1, 8'h24,   32'h0000_0100}, // R5 readback
    '{2'd0, 8'h04,   32'h0000_0100},
    '{2'd2, 8'h00,   32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt_i[k] = 1;
    @(negedge clk); evt_i[k] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {29'd0, irq_o}, 32'h0);
    rd_chk("R1 stat2", 8'h08, 32'h0);
    rd_chk("R1 mask g2w2", 8'h38, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].a, VEC[i].d);
        2'd1: rd_chk("R2/R5/R6 vec", VEC[i].a, VEC[i].d);
        2'd2: begin @(negedge clk); check("R7/R8/R9 vec irq", {29'd0, irq_o}, VEC[i].d); end
        default: pulse(int'(VEC[i].a));
      endcase
    end

    // R3: clear writes only 1s
    pulse(64); pulse(70);
    wr(8'h08, 32'h0000_0001);
    rd_chk("R3 partial clear", 8'h08, 32'h0000_0040);
    // R9: group2 enabled on two bits; clear one at a time
    pulse(64);
    wr(8'h38, 32'h0000_0041);
    @(negedge clk); check("R8 irq2 only", {29'd0, irq_o}, 32'h4);
    wr(8'h08, 32'h0000_0001);
    @(negedge clk); check("R9 still high", {29'd0, irq_o}, 32'h4);
    wr(8'h08, 32'h0000_0040);
    @(negedge clk); check("R9 drops", {29'd0, irq_o}, 32'h0);

    // R4: event and clear collide
    @(negedge clk); evt_i[3] = 1; wr_en = 1; addr = 8'h00; wdata = 32'h0000_0008;
    @(negedge clk); evt_i[3] = 0; wr_en = 0;
    rd_chk("R4 event wins", 8'h00, 32'h0000_0008);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R3 full clear", 8'h00, 32'h0);

    // R10 unmapped and latency
    wr(8'h14, 32'hDEAD_BEEF);
    rd_chk("R10 unmapped 0x0C", 8'h0C, 32'h0);
    rd_chk("R10 unmapped 0x1C", 8'h1C, 32'h0);
    rd_chk("R10 unmapped 0x40", 8'h40, 32'h0);
    rd_chk("R5 mask g0w1", 8'h14, 32'hDEAD_BEEF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule